// File: doc/BRIEF.md
# Three-Channel ADC Conversion Sequencer

This block controls a successive-approximation converter that has up to three sample-and-hold channels. Software sets a control word through a small register port. The word holds a channel-count mode, a start-source select and a clock divider. When the selected start source fires, the block pulses the sample strobes of all active hold channels in one cycle. It then counts converter clock enables; the number it counts depends on how many channels are active. At the end it raises a completion strobe and captures each active channel's 12-bit result from the converter data bus. It also sets a sticky end-of-conversion pending bit, which stays set until software writes a one to it.

The converter clock is not a separate clock. It is a one-cycle enable derived from the bus clock, once every (divider + 1) bus cycles. It can therefore never run faster than the bus clock. A divider of 1 gives half the bus clock rate. The analog part sits outside the block. A per-channel data bus that is valid while the completion strobe is high stands in for it.

Top module: `adc_seq_top`

## Requirements
- R1: The sample strobes `sh_strobe_o` are high for exactly one cycle, the first cycle in which `busy_o` is high. The pattern follows the mode field CTRL[1:0] sampled at start: 00 gives 3'b111, 01 gives 3'b001, 10 gives 3'b011 (bit 0 is channel one).
- R2: Mode code 11 never starts a conversion, whatever trigger arrives. `busy_o` stays low and the pending bit does not change.
- R3: A conversion keeps `busy_o` high for 2 + L*(D+1) consecutive cycles. L is 9 for one channel, 10 for two and 11 for three. D is the divider field CTRL[11:8] sampled at start.
- R4: The start source is chosen by CTRL[5:4]. The codes are: 00, a write of 1 to bit 0 of the command word at address 1; 01, a rising edge on `mot_trig_i`; 10, a rising edge on `ext_trig_i`; 11, no source. Sources that are not selected have no effect.
- R5: The hardware trigger pins pass through a synchroniser and an edge detector. A pin held high starts exactly one conversion.
- R6: A trigger that arrives while `busy_o` is high is dropped. The running conversion keeps its length, and no conversion follows once it ends.
- R7: At the end of a conversion, the pending bit (address 2, bit 0) and `eoc_irq_o` become 1. Writing 1 to address 2 bit 0 clears the bit.
- R8: If the end of a conversion and a clear write fall in the same cycle, the pending bit stays set.
- R9: The results of channels one, two and three are read from addresses 4, 5 and 6 in bits 11:0. Each is the value of its 12-bit slice of `conv_data_i` in the cycle `conv_done_o` is high.
- R10: A channel that is not active in a conversion keeps its previous result.
- R11: After reset, `busy_o`, `sh_strobe_o`, `conv_done_o`, `eoc_irq_o`, the pending bit and all results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| mot_trig_i | input | 1 | Motor-control start trigger |
| ext_trig_i | input | 1 | External start trigger pin |
| conv_data_i | input | 36 | Converter results, channel k in bits 12k+11:12k |
| adc_tick_o | output | 1 | Converter clock enable during conversion |
| sh_strobe_o | output | 3 | Sample strobes, one per hold channel |
| conv_done_o | output | 1 | Completion strobe, result capture cycle |
| busy_o | output | 1 | Conversion in progress |
| eoc_irq_o | output | 1 | End-of-conversion pending |

## Verification
Two events can fall in the same cycle. One is the hardware setting the pending bit at completion; the other is software clearing it. The bench waits until it sees `conv_done_o` high, then drives a write-one-to-clear in that same cycle, and expects the bit to read back as 1 afterwards. A second collision is a start trigger that arrives in the middle of a conversion. The bench judges it by the busy length, which must not change, and by `busy_o` staying low after the conversion ends.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W = 12;
    localparam int NCH   = 3;
    localparam int DIV_W = 4;
    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        MD_TRIPLE = 2'b00,
        MD_SINGLE = 2'b01,
        MD_DUAL   = 2'b10,
        MD_RSVD   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        TS_SOFT   = 2'b00,
        TS_MOTOR  = 2'b01,
        TS_EXTPIN = 2'b10,
        TS_NONE   = 2'b11
    } tsel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONV,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        tsel_e            tsel;
        mode_e            mode;
    } cfg_t;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_GO   = 3'd1;
    localparam logic [2:0] A_PEND = 3'd2;
    localparam logic [2:0] A_RES0 = 3'd4;

    function automatic logic [NCH-1:0] mode_mask(mode_e m);
        case (m)
            MD_TRIPLE: return 3'b111;
            MD_SINGLE: return 3'b001;
            MD_DUAL:   return 3'b011;
            default:   return 3'b000;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] mode_len(mode_e m);
        case (m)
            MD_TRIPLE: return CNT_W'(11);
            MD_SINGLE: return CNT_W'(9);
            MD_DUAL:   return CNT_W'(10);
            default:   return CNT_W'(0);
        endcase
    endfunction

    function automatic logic mode_ok(mode_e m);
        return m != MD_RSVD;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
    import adc_seq_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == div) cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div);

    // R3: the divider phase never passes the programmed limit while running
    assert_div_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(div)) |-> (cnt_q <= div));

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  tsel_e tsel,
    input  logic  soft_go,
    input  logic  mot_i,
    input  logic  ext_i,
    output logic  start_req
);

    localparam int NSRC = 2;

    logic [NSRC-1:0] pin_raw;
    logic [NSRC-1:0] hw_rise;

    assign pin_raw = {ext_i, mot_i};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic [SYNC-1:0] sh_q;
        logic            prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q   <= '0;
                prev_q <= 1'b0;
            end else begin
                sh_q   <= {sh_q[SYNC-2:0], pin_raw[g]};
                prev_q <= sh_q[SYNC-1];
            end
        end

        assign hw_rise[g] = sh_q[SYNC-1] && !prev_q;

        // R5: an edge event lasts a single cycle, so a held level yields one start
        assert_edge_pulse_R5: assert property (@(posedge clk) disable iff (rst)
            hw_rise[g] |=> !hw_rise[g]);
    end

    always_comb begin
        case (tsel)
            TS_SOFT:   start_req = soft_go;
            TS_MOTOR:  start_req = hw_rise[0];
            TS_EXTPIN: start_req = hw_rise[1];
            default:   start_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_seq_pkg::*;
#(
    parameter int N  = NCH,
    parameter int CW = CNT_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  cfg_t          cfg,
    input  logic          tick,
    output logic          busy,
    output logic [N-1:0]  sh_strobe,
    output logic          conv_done,
    output logic [N-1:0]  res_we,
    output logic          div_restart,
    output logic          div_run,
    output logic [DW-1:0] div_run_val
);

    st_e           st_q;
    logic [N-1:0]  mask_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] tcnt_q;
    logic [DW-1:0] div_q;
    logic          accept;

    assign accept = (st_q == ST_IDLE) && start_req && mode_ok(cfg.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mask_q <= '0;
            len_q  <= '0;
            tcnt_q <= '0;
            div_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        mask_q <= mode_mask(cfg.mode);
                        len_q  <= mode_len(cfg.mode);
                        div_q  <= cfg.div;
                        st_q   <= ST_SAMPLE;
                    end
                end
                ST_SAMPLE: begin
                    tcnt_q <= '0;
                    st_q   <= ST_CONV;
                end
                ST_CONV: begin
                    if (tick) begin
                        if (tcnt_q == len_q - 1'b1) st_q <= ST_DONE;
                        else                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (st_q != ST_IDLE);
    assign sh_strobe   = (st_q == ST_SAMPLE) ? mask_q : '0;
    assign conv_done   = (st_q == ST_DONE);
    assign res_we      = (st_q == ST_DONE) ? mask_q : '0;
    assign div_restart = (st_q == ST_SAMPLE);
    assign div_run     = (st_q == ST_CONV);
    assign div_run_val = div_q;

    // R1: sample strobes form a single-cycle pulse
    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
        (|sh_strobe) |=> !(|sh_strobe));

    // R2: a reserved mode leaves the sequencer idle
    assert_rsvd_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && start_req && cfg.mode == MD_RSVD) |=> (st_q == ST_IDLE));

    // R3: the clock-enable count stays below the conversion length
    assert_len_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CONV) |-> (tcnt_q < len_q));

    // R6: no restart while a conversion is running
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && start_req) |=> (st_q != ST_SAMPLE));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 mot_trig_i,
    input  logic                 ext_trig_i,
    input  logic [NCH*RES_W-1:0] conv_data_i,
    output logic                 adc_tick_o,
    output logic [NCH-1:0]       sh_strobe_o,
    output logic                 conv_done_o,
    output logic                 busy_o,
    output logic                 eoc_irq_o
);

    cfg_t             cfg_q;
    logic             pend_q;
    logic [RES_W-1:0] res_q [NCH];
    logic             soft_go;
    logic             pend_clr;
    logic             start_req;
    logic             tick;
    logic [NCH-1:0]   res_we;
    logic             div_restart;
    logic             div_run;
    logic [DIV_W-1:0] div_run_val;
    logic             conv_done;
    logic             unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:12], bus_wdata[7:6], bus_wdata[3:2]};

    assign soft_go  = bus_wr && (bus_addr == A_GO)   && bus_wdata[0];
    assign pend_clr = bus_wr && (bus_addr == A_PEND) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (bus_wr && bus_addr == A_CTRL) begin
            cfg_q.mode <= mode_e'(bus_wdata[1:0]);
            cfg_q.tsel <= tsel_e'(bus_wdata[5:4]);
            cfg_q.div  <= bus_wdata[8 +: DIV_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            pend_q <= 1'b0;
        else if (conv_done) pend_q <= 1'b1;
        else if (pend_clr)  pend_q <= 1'b0;
    end

    adc_trig_sel #(.SYNC(SYNC_STAGES)) trig_i (
        .clk       (clk),
        .rst       (rst),
        .tsel      (cfg_q.tsel),
        .soft_go   (soft_go),
        .mot_i     (mot_trig_i),
        .ext_i     (ext_trig_i),
        .start_req (start_req)
    );

    adc_conv_ctrl #(.N(NCH), .CW(CNT_W), .DW(DIV_W)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .cfg         (cfg_q),
        .tick        (tick),
        .busy        (busy_o),
        .sh_strobe   (sh_strobe_o),
        .conv_done   (conv_done),
        .res_we      (res_we),
        .div_restart (div_restart),
        .div_run     (div_run),
        .div_run_val (div_run_val)
    );

    adc_clk_div #(.DW(DIV_W)) div_i (
        .clk     (clk),
        .rst     (rst),
        .restart (div_restart),
        .run     (div_run),
        .div     (div_run_val),
        .tick    (tick)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_res
        always_ff @(posedge clk) begin
            if (rst)            res_q[k] <= '0;
            else if (res_we[k]) res_q[k] <= conv_data_i[k*RES_W +: RES_W];
        end

        // R10: a completion that does not include channel k leaves it untouched
        assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
            (conv_done && !res_we[k]) |=> $stable(res_q[k]));
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[1:0]       = cfg_q.mode;
                bus_rdata[5:4]       = cfg_q.tsel;
                bus_rdata[8 +: DIV_W] = cfg_q.div;
            end
            A_PEND: bus_rdata[0] = pend_q;
            default: begin
                for (int k = 0; k < NCH; k++) begin
                    if (bus_addr == A_RES0 + 3'(k)) bus_rdata[RES_W-1:0] = res_q[k];
                end
            end
        endcase
    end

    assign adc_tick_o  = tick;
    assign conv_done_o = conv_done;
    assign eoc_irq_o   = pend_q;

    // R7: completion always leaves the pending flag set
    assert_pend_set_R7: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> pend_q);

    // R8: set beats clear when both land in one cycle
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (conv_done && pend_clr) |=> pend_q);

endmodule

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;
    import adc_seq_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [2:0]           bus_addr = '0;
    logic                 bus_wr = 1'b0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 mot_trig_i = 1'b0;
    logic                 ext_trig_i = 1'b0;
    logic [NCH*RES_W-1:0] conv_data_i = '0;
    logic                 adc_tick_o;
    logic [NCH-1:0]       sh_strobe_o;
    logic                 conv_done_o;
    logic                 busy_o;
    logic                 eoc_irq_o;

    int total = 0;
    int bad = 0;
    int model_res [NCH] = '{0, 0, 0};

    always #5 clk = ~clk;

    adc_seq_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .mot_trig_i  (mot_trig_i),
        .ext_trig_i  (ext_trig_i),
        .conv_data_i (conv_data_i),
        .adc_tick_o  (adc_tick_o),
        .sh_strobe_o (sh_strobe_o),
        .conv_done_o (conv_done_o),
        .busy_o      (busy_o),
        .eoc_irq_o   (eoc_irq_o)
    );

    // mode, trigger select, divider, strobe mask, length, retrigger
    localparam int NV = 6;
    localparam int VM [NV] = '{1, 2, 0, 0, 2, 1};
    localparam int VT [NV] = '{0, 0, 0, 1, 2, 2};
    localparam int VD [NV] = '{0, 1, 2, 0, 3, 1};
    localparam int VK [NV] = '{1, 3, 7, 7, 3, 1};
    localparam int VL [NV] = '{9, 10, 11, 11, 10, 9};
    localparam int VR [NV] = '{0, 0, 1, 0, 0, 0};

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, int d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    function automatic int ctrl_word(int m, int t, int d);
        return (d << 8) | (t << 4) | m;
    endfunction

    function automatic int dval(int i, int ch);
        return (i * 293 + ch * 1187 + 77) & 'hFFF;
    endfunction

    task automatic no_start_window(string req, string what, int n);
        int seen = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (busy_o) seen = 1;
        end
        chk(req, what, seen, 0);
    endtask

    task automatic run_vec(int i);
        int n;
        int cyc;
        int v;
        bus_write(A_CTRL, ctrl_word(VM[i], VT[i], VD[i]));
        for (int ch = 0; ch < NCH; ch++) conv_data_i[ch*RES_W +: RES_W] = RES_W'(dval(i, ch));
        if (VT[i] == 0) bus_write(A_GO, 1);
        else begin
            @(negedge clk);
            if (VT[i] == 1) mot_trig_i = 1'b1;
            else            ext_trig_i = 1'b1;
        end
        n = 0;
        while (!busy_o && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk("R4", $sformatf("vec%0d start seen", i), int'(busy_o), 1);
        chk("R1", $sformatf("vec%0d strobe pattern", i), int'(sh_strobe_o), VK[i]);
        cyc = 0;
        while (busy_o && cyc < 100) begin
            cyc++;
            if (VR[i] != 0 && cyc == 3) begin
                bus_addr = A_GO; bus_wdata = 1; bus_wr = 1'b1;
            end
            if (cyc == 4) bus_wr = 1'b0;
            @(negedge clk);
            if (cyc == 1) chk("R1", $sformatf("vec%0d strobe drop", i), int'(sh_strobe_o), 0);
        end
        bus_wr = 1'b0;
        chk(VR[i] != 0 ? "R6" : "R3", $sformatf("vec%0d busy length", i), cyc, 2 + VL[i] * (VD[i] + 1));
        mot_trig_i = 1'b0;
        ext_trig_i = 1'b0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (VK[i][ch]) model_res[ch] = dval(i, ch);
            bus_read(A_RES0 + 3'(ch), v);
            chk(VK[i][ch] ? "R9" : "R10", $sformatf("vec%0d result ch%0d", i, ch), v, model_res[ch]);
        end
        bus_read(A_PEND, v);
        chk("R7", $sformatf("vec%0d pending set", i), v, 1);
        chk("R7", $sformatf("vec%0d irq out", i), int'(eoc_irq_o), 1);
        no_start_window("R6", $sformatf("vec%0d no queued start", i), 6);
        bus_write(A_PEND, 1);
        bus_read(A_PEND, v);
        chk("R7", $sformatf("vec%0d pending cleared", i), v, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        chk("R11", "busy after reset", int'(busy_o), 0);
        chk("R11", "strobes after reset", int'(sh_strobe_o), 0);
        chk("R11", "done after reset", int'(conv_done_o), 0);
        chk("R11", "irq after reset", int'(eoc_irq_o), 0);
        bus_read(A_PEND, v);
        chk("R11", "pending after reset", v, 0);
        for (int ch = 0; ch < NCH; ch++) begin
            bus_read(A_RES0 + 3'(ch), v);
            chk("R11", $sformatf("result ch%0d after reset", ch), v, 0);
        end

        for (int i = 0; i < NV; i++) run_vec(i);

        // R2: reserved mode with a software start
        bus_write(A_CTRL, ctrl_word(3, 0, 0));
        bus_write(A_GO, 1);
        no_start_window("R2", "reserved mode start", 12);
        bus_read(A_PEND, v);
        chk("R2", "reserved mode pending", v, 0);

        // R4: source 11 and unselected sources
        bus_write(A_CTRL, ctrl_word(1, 3, 0));
        bus_write(A_GO, 1);
        @(negedge clk); ext_trig_i = 1'b1; mot_trig_i = 1'b1;
        no_start_window("R4", "select none", 8);
        ext_trig_i = 1'b0; mot_trig_i = 1'b0;
        bus_write(A_CTRL, ctrl_word(1, 0, 0));
        @(negedge clk); ext_trig_i = 1'b1; mot_trig_i = 1'b1;
        no_start_window("R4", "pins ignored under software select", 8);
        ext_trig_i = 1'b0; mot_trig_i = 1'b0;
        bus_write(A_CTRL, ctrl_word(1, 2, 0));
        bus_write(A_GO, 1);
        @(negedge clk); mot_trig_i = 1'b1;
        no_start_window("R4", "command and motor ignored under pin select", 8);
        mot_trig_i = 1'b0;

        // R5: a held external level starts a single conversion
        @(negedge clk); ext_trig_i = 1'b1;
        n = 0;
        while (!busy_o && n < 10) begin @(negedge clk); n++; end
        chk("R5", "held level starts", int'(busy_o), 1);
        n = 0;
        while (busy_o && n < 100) begin @(negedge clk); n++; end
        no_start_window("R5", "held level no second start", 20);
        ext_trig_i = 1'b0;
        bus_write(A_PEND, 1);

        // R8: end of conversion and clear in the same cycle
        bus_write(A_CTRL, ctrl_word(1, 0, 0));
        bus_write(A_GO, 1);
        n = 0;
        while (!conv_done_o && n < 100) begin @(negedge clk); n++; end
        chk("R8", "done strobe seen", int'(conv_done_o), 1);
        bus_addr = A_PEND; bus_wdata = 1; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(A_PEND, v);
        chk("R8", "pending survives same-cycle clear", v, 1);
        bus_write(A_PEND, 1);
        bus_read(A_PEND, v);
        chk("R7", "later clear works", v, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule